// File: doc/BRIEF.md
# Processor Clock-Control State Machine

This block tracks the clock-control state of a processor core and drives the enable for the internal core clock. The core clock runs only in the normal operating state. Three events stop it. A retired halt instruction moves the block to a halt state. An active-low stop-clock request moves it to a stop-grant state. A nonzero write to a stop-grant timeout field moves it to a timed stop-grant state, which is used while core frequency and voltage are being changed.

From halt or stop-grant, a system inquire cycle moves the block into an inquire-service state. When the inquire cycle ends, the block returns to whichever of those two states it came from. A one-bit record of the origin is kept for this. While in stop-grant, a stopped bus clock moves the block to a stop-clock state. Each entry into stop-grant produces a one-cycle acknowledge pulse.

The parameter `LOW_POWER` selects the variant. When it is 1, the block has six states, including the timed stop-grant state. When it is 0, it has five states, timeout writes are ignored and the timeout field reads as zero. The block is clocked by the bus clock.

Top module: `clk_state_ctrl`

## Requirements
- R1: After reset, `stateCode` is 0 (normal), `coreClkEn` is 1, `stopGntAck` is 0 and `tmoRdData` is 0.
- R2: The state codes are: 0 normal, 1 halt, 2 stop grant, 3 inquire service, 4 timed stop grant, 5 stop clock. `coreClkEn` is 1 exactly when `stateCode` is 0.
- R3: In normal, a `haltDone` pulse moves the state to halt on the next cycle. In halt, `wakeEvt` with no inquire active moves the state back to normal on the next cycle.
- R4: In normal, `stopReqN` low moves the state to stop grant on the next cycle, even if `haltDone` is high in the same cycle. In stop grant, with the bus clock running and no inquire active, `stopReqN` high moves the state back to normal.
- R5: `stopGntAck` is high for exactly the first cycle of each stay in stop grant, however stop grant was entered.
- R6: `inquireAct` high in halt or stop grant moves the state to inquire service. When `inquireAct` goes low, the state returns to the state it came from. `inquireAct` has no effect in normal.
- R7: In stop grant, `busClkRun` low moves the state to stop clock. In stop clock, `busClkRun` high moves the state back to stop grant. Stop clock is reachable only from stop grant.
- R8 (LOW_POWER=1): In normal, with `stopReqN` high and `haltDone` low, a write of a nonzero value N moves the state to timed stop grant for exactly N cycles, then to normal. `tmoRdData` shows the remaining count: N, then N-1 and so on, reaching 0 on the return to normal.
- R9: A write of zero causes no transition. Writes made outside normal neither change the state nor load the count.
- R10 (LOW_POWER=0): Timeout writes are ignored, state 4 never occurs and `tmoRdData` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous active-low reset |
| haltDone | input | 1 | Pulse: a halt instruction retired |
| stopReqN | input | 1 | Active-low stop-clock request |
| inquireAct | input | 1 | A system inquire cycle is in progress |
| busClkRun | input | 1 | The bus clock input is running |
| wakeEvt | input | 1 | Interrupt or reset wake event |
| tmoWrEn | input | 1 | Write strobe for the timeout field |
| tmoWrData | input | TMO_W | Timeout value to write |
| stateCode | output | 3 | Current state code (see R2) |
| coreClkEn | output | 1 | Internal core clock enable |
| stopGntAck | output | 1 | One-cycle stop-grant acknowledge |
| tmoRdData | output | TMO_W | Timeout field readback, which holds the remaining count |

## Verification
The bench builds two instances that share their inputs: one with `LOW_POWER=1` and one with `LOW_POWER=0`, both with `TMO_W=8`. Comparing the two instances in the same cycle shows that the standard variant ignores the timeout writes that send the low-power variant into its timed state. Because both variants see every other sequence, each one is also checked on the halt, stop-grant, inquire and stop-clock paths.

// File: rtl/clk_state_pkg.sv
package clk_state_pkg;
  typedef enum logic [2:0] {
    ST_NORMAL  = 3'd0,
    ST_HALT    = 3'd1,
    ST_STPGNT  = 3'd2,
    ST_INQUIRE = 3'd3,
    ST_TIMED   = 3'd4,
    ST_STPCLK  = 3'd5
  } clkState_e;

  typedef struct packed {
    logic cntLoad;
    logic cntDec;
    logic saveRet;
    logic retIsHalt;
    logic ackSet;
  } ctrlStrobe_t;
endpackage

// File: rtl/clk_state_ctrl_fsm.sv
module clk_state_ctrl_fsm
  import clk_state_pkg::*;
#(
  parameter bit LOW_POWER = 1'b1,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltDone,
  input  logic             stopReqN,
  input  logic             inquireAct,
  input  logic             busClkRun,
  input  logic             wakeEvt,
  input  logic             tmoWrEn,
  input  logic [TMO_W-1:0] tmoWrData,
  input  logic             cntAtOne,
  input  logic             retHalt,
  output clkState_e        state,
  output ctrlStrobe_t      strobe
);
  clkState_e nxt;
  logic      wrNonZero;

  assign wrNonZero = LOW_POWER && tmoWrEn && (tmoWrData != '0);

  always_comb begin
    nxt    = state;
    strobe = '0;
    unique case (state)
      ST_NORMAL: begin
        if (!stopReqN)      nxt = ST_STPGNT;
        else if (haltDone)  nxt = ST_HALT;
        else if (wrNonZero) begin
          nxt            = ST_TIMED;
          strobe.cntLoad = 1'b1;
        end
      end
      ST_HALT: begin
        if (inquireAct) begin
          nxt              = ST_INQUIRE;
          strobe.saveRet   = 1'b1;
          strobe.retIsHalt = 1'b1;
        end else if (wakeEvt) nxt = ST_NORMAL;
      end
      ST_STPGNT: begin
        if (!busClkRun) nxt = ST_STPCLK;
        else if (inquireAct) begin
          nxt            = ST_INQUIRE;
          strobe.saveRet = 1'b1;
        end else if (stopReqN) nxt = ST_NORMAL;
      end
      ST_INQUIRE: begin
        if (!inquireAct) nxt = retHalt ? ST_HALT : ST_STPGNT;
      end
      ST_TIMED: begin
        strobe.cntDec = 1'b1;
        if (cntAtOne) nxt = ST_NORMAL;
      end
      ST_STPCLK: begin
        if (busClkRun) nxt = ST_STPGNT;
      end
      default: nxt = ST_NORMAL;
    endcase
    strobe.ackSet = (nxt == ST_STPGNT) && (state != ST_STPGNT);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_NORMAL;
    else       state <= nxt;
  end

  // R4
  stop_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_NORMAL && !stopReqN) |=> (state == ST_STPGNT));

  // R7
  stpclk_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_STPGNT && state != ST_STPCLK) |=> (state != ST_STPCLK));

  // R6
  inq_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state != ST_HALT && state != ST_STPGNT && state != ST_INQUIRE) |=> (state != ST_INQUIRE));

  // R3
  halt_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HALT && wakeEvt && !inquireAct) |=> (state == ST_NORMAL));

  // R10
  std_no_timed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !LOW_POWER |-> (state != ST_TIMED));
endmodule

// File: rtl/clk_state_dpath.sv
module clk_state_dpath
  import clk_state_pkg::*;
#(
  parameter bit LOW_POWER = 1'b1,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctrlStrobe_t      strobe,
  input  logic [TMO_W-1:0] tmoWrData,
  output logic             cntAtOne,
  output logic             retHalt,
  output logic             ackOut,
  output logic [TMO_W-1:0] fieldRd
);
  localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

  logic [TMO_W-1:0] cntQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cntQ    <= '0;
      retHalt <= 1'b0;
      ackOut  <= 1'b0;
    end else begin
      if (strobe.cntLoad)                  cntQ <= tmoWrData;
      else if (strobe.cntDec && cntQ != '0) cntQ <= cntQ - ONE;
      if (strobe.saveRet) retHalt <= strobe.retIsHalt;
      ackOut <= strobe.ackSet;
    end
  end

  assign cntAtOne = (cntQ == ONE);

  generate
    if (LOW_POWER) begin : g_lowPower
      assign fieldRd = cntQ;
    end else begin : g_standard
      assign fieldRd = '0;
    end
  endgenerate

  // R5
  ack_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    ackOut |=> !ackOut);

  // R8
  cnt_dec_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.cntDec && !strobe.cntLoad && cntQ != '0) |=> (cntQ == $past(cntQ) - ONE));
endmodule

// File: rtl/clk_state_ctrl.sv
module clk_state_ctrl
  import clk_state_pkg::*;
#(
  parameter bit LOW_POWER = 1'b1,
  parameter int TMO_W     = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             haltDone,
  input  logic             stopReqN,
  input  logic             inquireAct,
  input  logic             busClkRun,
  input  logic             wakeEvt,
  input  logic             tmoWrEn,
  input  logic [TMO_W-1:0] tmoWrData,
  output logic [2:0]       stateCode,
  output logic             coreClkEn,
  output logic             stopGntAck,
  output logic [TMO_W-1:0] tmoRdData
);
  clkState_e   state;
  ctrlStrobe_t strobe;
  logic        cntAtOne;
  logic        retHalt;

  clk_state_ctrl_fsm #(.LOW_POWER(LOW_POWER), .TMO_W(TMO_W)) u_fsm (
    .clk(clk), .rstN(rstN), .haltDone(haltDone), .stopReqN(stopReqN),
    .inquireAct(inquireAct), .busClkRun(busClkRun), .wakeEvt(wakeEvt),
    .tmoWrEn(tmoWrEn), .tmoWrData(tmoWrData), .cntAtOne(cntAtOne),
    .retHalt(retHalt), .state(state), .strobe(strobe)
  );

  clk_state_dpath #(.LOW_POWER(LOW_POWER), .TMO_W(TMO_W)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .tmoWrData(tmoWrData),
    .cntAtOne(cntAtOne), .retHalt(retHalt), .ackOut(stopGntAck),
    .fieldRd(tmoRdData)
  );

  assign stateCode = state;
  assign coreClkEn = (state == ST_NORMAL);

  // R2
  clk_en_ack_chk: assert property (@(posedge clk) disable iff (!rstN)
    stopGntAck |-> (!coreClkEn && stateCode == 3'd2));
endmodule

// File: tb/clk_state_ctrl_tb.sv
module clk_state_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int TW = 8;

  typedef struct {
    logic [2:0]    lpState;
    logic          lpAck;
    logic [TW-1:0] lpRd;
    logic [2:0]    sdState;
    logic          sdAck;
    string         tag;
  } expItem_t;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic haltDone = 1'b0, stopReqN = 1'b1, inquireAct = 1'b0, busClkRun = 1'b1;
  logic wakeEvt = 1'b0, tmoWrEn = 1'b0;
  logic [TW-1:0] tmoWrData = '0;

  logic [2:0] lpCode, sdCode;
  logic lpEn, sdEn, lpAck, sdAck;
  logic [TW-1:0] lpRdD, sdRdD;

  int nCompared = 0;
  int nMismatch = 0;
  expItem_t expQ[$];
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_state_ctrl #(.LOW_POWER(1'b1), .TMO_W(TW)) u_dut (
    .clk(clk), .rstN(rstN), .haltDone(haltDone), .stopReqN(stopReqN),
    .inquireAct(inquireAct), .busClkRun(busClkRun), .wakeEvt(wakeEvt),
    .tmoWrEn(tmoWrEn), .tmoWrData(tmoWrData), .stateCode(lpCode),
    .coreClkEn(lpEn), .stopGntAck(lpAck), .tmoRdData(lpRdD));

  clk_state_ctrl #(.LOW_POWER(1'b0), .TMO_W(TW)) u_dut_std (
    .clk(clk), .rstN(rstN), .haltDone(haltDone), .stopReqN(stopReqN),
    .inquireAct(inquireAct), .busClkRun(busClkRun), .wakeEvt(wakeEvt),
    .tmoWrEn(tmoWrEn), .tmoWrData(tmoWrData), .stateCode(sdCode),
    .coreClkEn(sdEn), .stopGntAck(sdAck), .tmoRdData(sdRdD));

  task automatic cmp(string tag, string what, int act, int exp);
    nCompared++;
    if (act != exp) begin
      nMismatch++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // Driver: applies one cycle of inputs at the falling edge and queues the expectation.
  task automatic step(bit hd, bit srN, bit inq, bit bcr, bit wk, bit we, int wd,
                      int eLp, bit eAck, int eRd, int eSd, string tag);
    expItem_t it;
    @(negedge clk);
    haltDone = hd; stopReqN = srN; inquireAct = inq; busClkRun = bcr;
    wakeEvt = wk; tmoWrEn = we; tmoWrData = TW'(wd);
    it.lpState = 3'(eLp); it.lpAck = eAck; it.lpRd = TW'(eRd);
    it.sdState = 3'(eSd); it.sdAck = eAck; it.tag = tag;
    expQ.push_back(it);
  endtask

  // Monitor: compares after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (expQ.size() > 0) begin
        expItem_t it;
        it = expQ.pop_front();
        cmp(it.tag, "lp state", int'(lpCode), int'(it.lpState));
        cmp(it.tag, "lp ack", int'(lpAck), int'(it.lpAck));
        cmp(it.tag, "lp rd", int'(lpRdD), int'(it.lpRd));
        cmp(it.tag, "lp clkEn", int'(lpEn), int'(it.lpState == 3'd0));
        cmp(it.tag, "sd state", int'(sdCode), int'(it.sdState));
        cmp(it.tag, "sd ack", int'(sdAck), int'(it.sdAck));
        cmp(it.tag, "sd rd R10", int'(sdRdD), 0);
        cmp(it.tag, "sd clkEn", int'(sdEn), int'(it.sdState == 3'd0));
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    nCompared++; nMismatch++;
    $display("FAIL watchdog: actual hung expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 2 + 2);
    // R1 reset state
    cmp("R1", "state", int'(lpCode), 0);
    cmp("R1", "clkEn", int'(lpEn), 1);
    cmp("R1", "ack", int'(lpAck), 0);
    cmp("R1", "rd", int'(lpRdD), 0);
    cmp("R1", "sd state", int'(sdCode), 0);
    @(negedge clk); rstN = 1'b1;
    step(0,1,0,1,0,0,0, 0,0,0,0, "R1");
    // R3 halt and wake
    step(1,1,0,1,0,0,0, 1,0,0,1, "R3");
    step(0,1,0,1,0,0,0, 1,0,0,1, "R3");
    step(0,1,0,1,1,0,0, 0,0,0,0, "R3");
    // R4 stop request wins over halt; R5 ack
    step(1,0,0,1,0,0,0, 2,1,0,2, "R4");
    step(0,0,0,1,0,0,0, 2,0,0,2, "R5");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R4");
    // R6 inquire from stop grant
    step(0,0,0,1,0,0,0, 2,1,0,2, "R5");
    step(0,0,1,1,0,0,0, 3,0,0,3, "R6");
    step(0,0,1,1,0,0,0, 3,0,0,3, "R6");
    step(0,0,0,1,0,0,0, 2,1,0,2, "R6");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R4");
    // R6 inquire from halt, and ignored in normal
    step(1,1,0,1,0,0,0, 1,0,0,1, "R3");
    step(0,1,1,1,0,0,0, 3,0,0,3, "R6");
    step(0,1,0,1,0,0,0, 1,0,0,1, "R6");
    step(0,1,0,1,1,0,0, 0,0,0,0, "R3");
    step(0,1,1,1,0,0,0, 0,0,0,0, "R6");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R6");
    // R7 stop clock
    step(0,0,0,1,0,0,0, 2,1,0,2, "R5");
    step(0,0,0,0,0,0,0, 5,0,0,5, "R7");
    step(0,0,0,0,0,0,0, 5,0,0,5, "R7");
    step(0,0,0,1,0,0,0, 2,1,0,2, "R7");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R4");
    step(0,1,0,0,0,0,0, 0,0,0,0, "R7");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R7");
    // R8 timed stop grant for N=3 cycles; R10 standard unaffected
    step(0,1,0,1,0,1,3, 4,0,3,0, "R8");
    step(0,1,0,1,0,0,0, 4,0,2,0, "R8");
    step(0,1,0,1,0,0,0, 4,0,1,0, "R8");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R8");
    // R8 boundary N=1
    step(0,1,0,1,0,1,1, 4,0,1,0, "R8");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R8");
    // R9 zero write, write in halt, write during timed state
    step(0,1,0,1,0,1,0, 0,0,0,0, "R9");
    step(1,1,0,1,0,0,0, 1,0,0,1, "R9");
    step(0,1,0,1,0,1,5, 1,0,0,1, "R9");
    step(0,1,0,1,1,0,0, 0,0,0,0, "R9");
    step(0,1,0,1,0,1,2, 4,0,2,0, "R9");
    step(0,1,0,1,0,1,7, 4,0,1,0, "R9");
    step(0,1,0,1,0,0,0, 0,0,0,0, "R9");
    // R10 maximum write still ignored in standard variant
    step(0,1,0,1,0,1,255, 4,0,255,0, "R10");
    step(0,1,0,1,0,0,0, 4,0,254,0, "R10");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end
endmodule